// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the reservation behind an atomic read-modify-write built from a load-linked and a store-conditional. A load-linked request records the address and access size (word or doubleword). Between that load and the matching store-conditional, the block watches two things that destroy the reservation. The first is a snoop strobe, which reports a write by another agent to some address. The second is an exception-return event.

When a store-conditional arrives, the block checks whether the reservation is still intact and matches the request. One cycle later it reports three things: whether the memory write may go ahead, the status value (1 or 0) to be written back into the source register, and whether either request was misaligned. Only one reservation exists at a time. Every store-conditional consumes it.

Top module: `llsc_monitor`

## Requirements
- R1: A store-conditional whose address and size equal those of a held reservation, and that meets no other cause of failure, succeeds. One cycle after the request, `sc_done_o`=1, `sc_wr_en_o`=1 and `sc_status_o`=1.
- R2: A snoop write whose address falls in the same aligned 8-byte block as the reserved address clears the reservation. Blocks are compared on address bits [AW-1:3]. A snoop to any other block leaves the reservation intact.
- R3: An exception-return event clears the reservation.
- R4: A failed store-conditional gives `sc_done_o`=1, `sc_wr_en_o`=0 and `sc_status_o`=0. When no store-conditional was requested, `sc_done_o`, `sc_wr_en_o` and `sc_status_o` are all 0.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails, so a second store-conditional to the same address fails.
- R6: A store-conditional with no reservation held, including the first one after reset, fails.
- R7: A word request whose address bits [1:0] are not zero, or a doubleword request whose address bits [2:0] are not zero, raises `addr_fault_o` one cycle later. A misaligned store-conditional also fails.
- R8: A misaligned load-linked sets no reservation and leaves any existing reservation unchanged.
- R9: A new aligned load-linked replaces the previous reservation.
- R10: A store-conditional fails when a snoop write to the reserved block, or an exception-return event, arrives in the same cycle.
- R11: A load-linked in the same cycle as a store-conditional has two effects. The store-conditional is judged on the old reservation, and the new reservation is then held. A load-linked in the same cycle as a snoop to its own block still sets its reservation.
- R12: A store-conditional whose address or size differs from the reservation fails.
- R13: During reset and immediately after it, all outputs are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ll_valid_i | input | 1 | Load-linked request strobe |
| ll_addr_i | input | AW | Load-linked byte address |
| ll_dword_i | input | 1 | Load-linked size: 1 = doubleword, 0 = word |
| snoop_valid_i | input | 1 | Write by another agent observed |
| snoop_addr_i | input | AW | Address of the observed write |
| eret_i | input | 1 | Exception-return event |
| sc_valid_i | input | 1 | Store-conditional request strobe |
| sc_addr_i | input | AW | Store-conditional byte address |
| sc_dword_i | input | 1 | Store-conditional size: 1 = doubleword, 0 = word |
| sc_done_o | output | 1 | Store-conditional result valid |
| sc_wr_en_o | output | 1 | Memory write may proceed |
| sc_status_o | output | XLEN | Value to write back to the source register (1 or 0) |
| addr_fault_o | output | 1 | Misaligned load-linked or store-conditional seen |

## Verification
The collision that matters most is a clearing event arriving in the same cycle as the store-conditional it would defeat. The bench provokes it by driving a snoop to the reserved block, and separately an exception return, in the same cycle as an otherwise matching store-conditional. In both cases it expects a write denial and a status of 0. As a contrast, it drives the same store-conditional alongside a snoop to an unrelated block and expects success. A second collision, a load-linked alongside a store-conditional or a snoop, is judged by the outcome of a later store-conditional.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    localparam int unsigned WORD_BYTES  = 4;
    localparam int unsigned DWORD_BYTES = 8;
    localparam int unsigned WORD_LSB    = $clog2(WORD_BYTES);
    localparam int unsigned BLK_LSB     = $clog2(DWORD_BYTES);

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } acc_size_e;
endpackage

// File: rtl/llsc_align.sv
module llsc_align
    import llsc_pkg::*;
(
    input  logic [BLK_LSB-1:0] addr_lsb_i,
    input  acc_size_e          size_i,
    output logic               misal_o
);
    always_comb begin
        if (size_i == SZ_DWORD) begin
            misal_o = (addr_lsb_i != '0);
        end else begin
            misal_o = (addr_lsb_i[WORD_LSB-1:0] != '0);
        end
    end
endmodule

// File: rtl/llsc_block_cmp.sv
module llsc_block_cmp #(
    parameter int unsigned TAG_W = 29
) (
    input  logic             en_i,
    input  logic [TAG_W-1:0] tag_a_i,
    input  logic [TAG_W-1:0] tag_b_i,
    output logic             hit_o
);
    assign hit_o = en_i && (tag_a_i == tag_b_i);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ll_valid_i,
    input  logic [AW-1:0]   ll_addr_i,
    input  logic            ll_dword_i,
    input  logic            snoop_valid_i,
    input  logic [AW-1:0]   snoop_addr_i,
    input  logic            eret_i,
    input  logic            sc_valid_i,
    input  logic [AW-1:0]   sc_addr_i,
    input  logic            sc_dword_i,
    output logic            sc_done_o,
    output logic            sc_wr_en_o,
    output logic [XLEN-1:0] sc_status_o,
    output logic            addr_fault_o
);
    localparam int unsigned TAG_W = AW - BLK_LSB;

    typedef struct packed {
        logic          link_vld;
        logic [AW-1:0] link_addr;
        acc_size_e     link_size;
        logic          done;
        logic          wr;
        logic          fault;
    } state_t;

    state_t st_d, st_q;

    logic ll_misal, sc_misal, snoop_hit, sc_match;

    llsc_align u_ll_align (
        .addr_lsb_i (ll_addr_i[BLK_LSB-1:0]),
        .size_i     (acc_size_e'(ll_dword_i)),
        .misal_o    (ll_misal)
    );

    llsc_align u_sc_align (
        .addr_lsb_i (sc_addr_i[BLK_LSB-1:0]),
        .size_i     (acc_size_e'(sc_dword_i)),
        .misal_o    (sc_misal)
    );

    llsc_block_cmp #(.TAG_W(TAG_W)) u_snoop_cmp (
        .en_i    (snoop_valid_i && st_q.link_vld),
        .tag_a_i (snoop_addr_i[AW-1:BLK_LSB]),
        .tag_b_i (st_q.link_addr[AW-1:BLK_LSB]),
        .hit_o   (snoop_hit)
    );

    logic unused_snoop_lsb;
    assign unused_snoop_lsb = ^snoop_addr_i[BLK_LSB-1:0];

    assign sc_match = st_q.link_vld
                   && (sc_addr_i == st_q.link_addr)
                   && (acc_size_e'(sc_dword_i) == st_q.link_size);

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.wr    = 1'b0;
        st_d.fault = 1'b0;

        // judge the store-conditional against the reservation held now
        if (sc_valid_i) begin
            st_d.done     = 1'b1;
            st_d.fault    = sc_misal;
            st_d.wr       = sc_match && !sc_misal && !snoop_hit && !eret_i;
            st_d.link_vld = 1'b0;
        end

        if (snoop_hit || eret_i) begin
            st_d.link_vld = 1'b0;
        end

        // a load-linked takes effect after every clearing event of its cycle
        if (ll_valid_i) begin
            if (ll_misal) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.link_vld  = 1'b1;
                st_d.link_addr = ll_addr_i;
                st_d.link_size = acc_size_e'(ll_dword_i);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{link_vld: 1'b0, link_addr: '0, link_size: SZ_WORD,
                      done: 1'b0, wr: 1'b0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sc_done_o    = st_q.done;
    assign sc_wr_en_o   = st_q.wr;
    assign sc_status_o  = {{(XLEN-1){1'b0}}, st_q.wr};
    assign addr_fault_o = st_q.fault;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int unsigned AW   = 32,
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            ll_valid_i,
    input logic [AW-1:0]   snoop_addr_i,
    input logic            snoop_valid_i,
    input logic            eret_i,
    input logic            sc_valid_i,
    input logic [AW-1:0]   sc_addr_i,
    input logic            sc_dword_i,
    input logic            sc_done_o,
    input logic            sc_wr_en_o,
    input logic [XLEN-1:0] sc_status_o,
    input logic            addr_fault_o
);
    // R1
    sc_done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_valid_i |=> sc_done_o);

    // R4
    no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sc_valid_i |=> (!sc_done_o && !sc_wr_en_o && sc_status_o == '0));

    // R7
    misaligned_sc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_valid_i && (sc_dword_i ? (sc_addr_i[2:0] != 3'd0) : (sc_addr_i[1:0] != 2'd0)))
        |=> (addr_fault_o && !sc_wr_en_o));

    // R10
    snoop_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_valid_i && snoop_valid_i && ((snoop_addr_i >> 3) == (sc_addr_i >> 3)))
        |=> !sc_wr_en_o);

    // R3
    eret_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_valid_i && eret_i) |=> !sc_wr_en_o);

    // R5
    back_to_back_sc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_valid_i && $past(sc_valid_i) && !$past(ll_valid_i)) |=> !sc_wr_en_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .XLEN(XLEN)) chk_i (.*);

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/100ps
module llsc_monitor_tb_top;
    localparam int unsigned AW   = 32;
    localparam int unsigned XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ll_valid = 1'b0, ll_dword = 1'b0;
    logic [AW-1:0]   ll_addr = '0;
    logic            snoop_valid = 1'b0;
    logic [AW-1:0]   snoop_addr = '0;
    logic            eret = 1'b0;
    logic            sc_valid = 1'b0, sc_dword = 1'b0;
    logic [AW-1:0]   sc_addr = '0;
    logic            sc_done, sc_wr_en, addr_fault;
    logic [XLEN-1:0] sc_status;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  done;
        logic  wr;
        logic  fault;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    llsc_monitor #(.AW(AW), .XLEN(XLEN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ll_valid_i(ll_valid), .ll_addr_i(ll_addr), .ll_dword_i(ll_dword),
        .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
        .eret_i(eret),
        .sc_valid_i(sc_valid), .sc_addr_i(sc_addr), .sc_dword_i(sc_dword),
        .sc_done_o(sc_done), .sc_wr_en_o(sc_wr_en),
        .sc_status_o(sc_status), .addr_fault_o(addr_fault)
    );

    task automatic check(input string tag, input logic d, input logic w, input logic f);
        logic [XLEN-1:0] st_exp;
        st_exp = (d && w) ? XLEN'(1) : '0;
        total++;
        if (sc_done !== d || sc_wr_en !== w || sc_status !== st_exp || addr_fault !== f) begin
            bad++;
            $display("FAIL %s: got done=%0b wr=%0b status=%0h fault=%0b exp done=%0b wr=%0b status=%0h fault=%0b",
                     tag, sc_done, sc_wr_en, sc_status, addr_fault, d, w, st_exp, f);
        end
    endtask

    // one request cycle; the expected result appears one cycle later
    task automatic step(input logic llv, input logic [AW-1:0] lla, input logic lld,
                        input logic snv, input logic [AW-1:0] sna, input logic er,
                        input logic scv, input logic [AW-1:0] sca, input logic scd,
                        input logic exp_wr, input logic exp_fault, input string tag);
        exp_t e;
        @(negedge clk);
        ll_valid = llv; ll_addr = lla; ll_dword = lld;
        snoop_valid = snv; snoop_addr = sna; eret = er;
        sc_valid = scv; sc_addr = sca; sc_dword = scd;
        e.done = scv; e.wr = exp_wr; e.fault = exp_fault; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic ll(input logic [AW-1:0] a, input logic d, input logic flt, input string tag);
        step(1, a, d, 0, '0, 0, 0, '0, 0, 0, flt, tag);
    endtask

    task automatic sc(input logic [AW-1:0] a, input logic d, input logic ok, input logic flt, input string tag);
        step(0, '0, 0, 0, '0, 0, 1, a, d, ok, flt, tag);
    endtask

    task automatic snoop(input logic [AW-1:0] a, input string tag);
        step(0, '0, 0, 1, a, 0, 0, '0, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, '0, 0, 0, '0, 0, 0, 0, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, e.done, e.wr, e.fault);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog (all requirements): got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R13 during reset", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 / R13: nothing reserved after reset
        sc(32'h100, 0, 0, 0, "R6 sc with no reservation");
        // R1 then R5
        ll(32'h100, 0, 0, "R1 ll word");
        sc(32'h100, 0, 1, 0, "R1 sc word succeeds");
        sc(32'h100, 0, 0, 0, "R5 second sc fails");
        // R2 snoop inside the block
        ll(32'h200, 1, 0, "R2 ll dword");
        snoop(32'h204, "R2 snoop same block");
        sc(32'h200, 1, 0, 0, "R2 sc after hit snoop fails");
        ll(32'h200, 1, 0, "R2 ll dword again");
        snoop(32'h208, "R2 snoop next block");
        sc(32'h200, 1, 1, 0, "R2 sc after miss snoop succeeds");
        ll(32'h100, 0, 0, "R2 ll word");
        snoop(32'h104, "R2 snoop other word same block");
        sc(32'h100, 0, 0, 0, "R2 word link broken by block snoop");
        // R3
        ll(32'h300, 0, 0, "R3 ll");
        step(0, '0, 0, 0, '0, 1, 0, '0, 0, 0, 0, "R3 eret");
        sc(32'h300, 0, 0, 0, "R3 sc after eret fails");
        // R7
        ll(32'h302, 0, 1, "R7 misaligned ll word");
        sc(32'h306, 0, 0, 1, "R7 misaligned sc word");
        ll(32'h304, 1, 1, "R7 misaligned ll dword");
        ll(32'h108, 1, 0, "R7 aligned ll dword");
        sc(32'h10C, 1, 0, 1, "R7 misaligned sc dword fails");
        // R8
        ll(32'h400, 0, 0, "R8 ll aligned");
        ll(32'h401, 0, 1, "R8 misaligned ll");
        sc(32'h400, 0, 1, 0, "R8 old reservation kept");
        // R9
        ll(32'h500, 0, 0, "R9 ll first");
        ll(32'h600, 0, 0, "R9 ll second");
        sc(32'h500, 0, 0, 0, "R9 old address fails");
        ll(32'h500, 0, 0, "R9 ll first");
        ll(32'h600, 0, 0, "R9 ll second");
        sc(32'h600, 0, 1, 0, "R9 new address succeeds");
        // R12
        ll(32'h700, 1, 0, "R12 ll dword");
        sc(32'h700, 0, 0, 0, "R12 size mismatch fails");
        ll(32'h700, 0, 0, "R12 ll word");
        sc(32'h704, 0, 0, 0, "R12 address mismatch fails");
        // R10 same-cycle collisions
        ll(32'h800, 0, 0, "R10 ll");
        step(0, '0, 0, 1, 32'h800, 0, 1, 32'h800, 0, 0, 0, "R10 snoop with sc fails");
        ll(32'h800, 0, 0, "R10 ll");
        step(0, '0, 0, 0, '0, 1, 1, 32'h800, 0, 0, 0, "R10 eret with sc fails");
        ll(32'h800, 0, 0, "R10 ll");
        step(0, '0, 0, 1, 32'h900, 0, 1, 32'h800, 0, 1, 0, "R10 unrelated snoop with sc succeeds");
        // R11
        step(1, 32'h900, 0, 0, '0, 0, 1, 32'h900, 0, 0, 0, "R11 ll with sc judged on old");
        sc(32'h900, 0, 1, 0, "R11 new link held");
        step(1, 32'hA00, 1, 1, 32'hA00, 0, 0, '0, 0, 0, 0, "R11 ll with snoop");
        sc(32'hA00, 1, 1, 0, "R11 link survives own-cycle snoop");
        idle("R4 idle");
        idle("R4 idle");
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule